// File: doc/BRIEF.md
# Serial Configuration Register Target

This block is the receiving end of a four-wire serial configuration link. An external master drives a serial clock, a load strobe, a write-select level and a serial data line; the block returns one serial data line. Everything runs on the local system clock. The four incoming pins are passed through two-flop synchronizers, and rising edges of the serial clock are detected on the system clock, so the serial clock must be several times slower than the system clock.

A transaction first shifts in a 12-bit address, most significant bit first, on rising serial clock edges while load is low. When the write-select pin is high, 32 data bits follow in the same order. A rising serial clock edge seen while load is high closes the frame. On a write, the collected word is stored in the addressed register. On a read, the addressed register is fetched and sent back on the data output, least significant bit first, across the next 32 serial clock pulses. The bank holds a parameterized number of 32-bit registers, and all of them reset to zero.

Top module: `cfg_serial_target`

## Requirements
- R1: After reset the serial data output is 0 and every register in the bank reads back as zero.
- R2: While load is low, each rising serial clock edge shifts one bit of the 12-bit address, most significant bit first.
- R3: When write-select is high, the 32 bits after the address are taken most significant bit first, and a rising serial clock edge with load high writes that word to the addressed register.
- R4: When write-select is low at the load edge, the addressed register is fetched. The data output stays 0 until the first following serial clock pulse, rising edge k (1 to 32) presents bit k-1, and the output changes at no other time.
- R5: An address equal to or above the bank size (8 by default) reads back as zero, and a write to it leaves every register unchanged.
- R6: The 32 read-out pulses are not taken as address bits, so a frame sent straight after a read is decoded correctly.
- R7: Bits after the 44th in a write frame are ignored, and the bit count restarts when load falls, so the next frame begins cleanly at its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scfg_clk_i | input | 1 | Serial clock from the master (asynchronous) |
| scfg_load_i | input | 1 | Load strobe that closes a frame (asynchronous) |
| scfg_write_i | input | 1 | High selects write, low selects read (asynchronous) |
| scfg_sdi_i | input | 1 | Serial data from the master (asynchronous) |
| scfg_sdo_o | output | 1 | Serial read data to the master, least significant bit first |

## Verification
A bit counter that has drifted by one position shows up at the ports as a rotated or shifted address. The next read-back then returns the contents of a neighbouring register, or zero, within the same transaction. If the read-out counter failed to suppress collection, the bad address would appear only in the transaction that follows a read, so the bench runs reads and writes back to back. A shift register loaded one position off appears on the output at the very first read-out pulse, and a load that should not happen appears as a nonzero bit before that pulse.

// File: rtl/cfg_serial_pkg.sv
// Shared constants for the serial configuration target.
// Assumes a fixed frame: address field first, then the data field on writes.
package cfg_serial_pkg;
    localparam int unsigned ADDR_BITS = 12;
    localparam int unsigned DATA_BITS = 32;
    localparam int unsigned BANK_REGS = 8;
endpackage

// File: rtl/cfg_pin_sync.sv
// Multi-bit two-stage (or deeper) synchronizer for asynchronous pins.
// Assumes each bit is an independent slow level, so there is no bus coherency.
module cfg_pin_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Shift the pin value through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[b] <= '0;
            else        chain[b] <= {chain[b][STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain[b][STAGES-1];
    end
endmodule

// File: rtl/cfg_frame_collect.sv
// Detects serial clock and load edges and assembles the address and data fields.
// Fields arrive MSB first. A rising edge while load is high issues a one-cycle
// write or read strobe. Collection pauses while a read-out is in progress.
module cfg_frame_collect #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned FRAME_W = ADDR_W + DATA_W,
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sclk,
    input  logic              s_load,
    input  logic              s_write,
    input  logic              s_sdi,
    input  logic              rd_busy,
    output logic              sclk_rise,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);
    logic              sclk_q, load_q, load_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] addr_sr;
    logic [DATA_W-1:0] data_sr;

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            load_q <= 1'b0;
        end else begin
            sclk_q <= s_sclk;
            load_q <= s_load;
        end
    end

    assign sclk_rise = s_sclk & ~sclk_q;
    assign load_fall = load_q & ~s_load;

    // Shift in address bits, then data bits on writes; clear when load falls.
    always_ff @(posedge clk) begin
        if (!rst_n || load_fall) begin
            bit_cnt <= '0;
            addr_sr <= '0;
            data_sr <= '0;
        end else if (sclk_rise && !s_load && !rd_busy) begin
            if (bit_cnt < CNT_W'(ADDR_W)) begin
                addr_sr <= {addr_sr[ADDR_W-2:0], s_sdi};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (s_write && bit_cnt < CNT_W'(FRAME_W)) begin
                data_sr <= {data_sr[DATA_W-2:0], s_sdi};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Issue the commit strobe one cycle after the closing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
        end else begin
            wr_stb <= sclk_rise & s_load & s_write;
            rd_stb <= sclk_rise & s_load & ~s_write;
        end
    end

    assign addr_o    = addr_sr;
    assign data_o    = data_sr;
    assign bit_cnt_o = bit_cnt;
endmodule

// File: rtl/cfg_reg_bank.sv
// Bank of DATA_W-bit registers, all reset to zero.
// Addresses outside the bank read as zero and never match a write.
module cfg_reg_bank #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREGS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] regs [NREGS];

    // Store the word into the register whose index equals the address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n)                                  regs[i] <= '0;
            else if (wr_stb && addr_i == ADDR_W'(i))     regs[i] <= wdata_i;
        end
    end

    // Select the addressed register, or zero when nothing matches.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (addr_i == ADDR_W'(i)) rdata_o = regs[i];
        end
    end
endmodule

// File: rtl/cfg_readout.sv
// Serializes a fetched word LSB first. Output is 0 after the fetch, and each
// later serial clock rise (load low) advances one bit for DATA_W pulses.
module cfg_readout #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              sclk_rise,
    input  logic              s_load,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              sdo_o,
    output logic              busy_o,
    output logic [CNT_W-1:0]  cnt_o
);
    logic [DATA_W:0]  shreg;
    logic [CNT_W-1:0] remain;

    // Load the fetched word behind a leading zero, then shift once per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            remain <= '0;
        end else if (rd_stb) begin
            shreg  <= {rdata_i, 1'b0};
            remain <= CNT_W'(DATA_W);
        end else if (sclk_rise && !s_load && remain != '0) begin
            shreg  <= shreg >> 1;
            remain <= remain - 1'b1;
        end
    end

    assign sdo_o  = shreg[0];
    assign busy_o = (remain != '0);
    assign cnt_o  = remain;
endmodule

// File: rtl/cfg_serial_target.sv
// Top of the serial configuration target: pin synchronizers, frame collector,
// register bank and read-out serializer. The serial clock must be at least
// several system clocks high and low so each edge is seen once.
module cfg_serial_target #(
    parameter int unsigned ADDR_W = cfg_serial_pkg::ADDR_BITS,
    parameter int unsigned DATA_W = cfg_serial_pkg::DATA_BITS,
    parameter int unsigned NREGS  = cfg_serial_pkg::BANK_REGS,
    localparam int unsigned FCNT_W = $clog2(ADDR_W + DATA_W + 1),
    localparam int unsigned RCNT_W = $clog2(DATA_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scfg_clk_i,
    input  logic scfg_load_i,
    input  logic scfg_write_i,
    input  logic scfg_sdi_i,
    output logic scfg_sdo_o
);
    logic [3:0]        pins_s;
    logic              sclk_rise, wr_stb, rd_stb, rd_busy;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata;
    logic [FCNT_W-1:0] bit_cnt;
    logic [RCNT_W-1:0] rd_cnt;

    cfg_pin_sync #(.WIDTH(4), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scfg_sdi_i, scfg_write_i, scfg_load_i, scfg_clk_i}),
        .sync_o  (pins_s)
    );

    cfg_frame_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_sclk    (pins_s[0]),
        .s_load    (pins_s[1]),
        .s_write   (pins_s[2]),
        .s_sdi     (pins_s[3]),
        .rd_busy   (rd_busy),
        .sclk_rise (sclk_rise),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .addr_o    (addr),
        .data_o    (wdata),
        .bit_cnt_o (bit_cnt)
    );

    cfg_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );

    cfg_readout #(.DATA_W(DATA_W)) u_readout (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .sclk_rise (sclk_rise),
        .s_load    (pins_s[1]),
        .rdata_i   (rdata),
        .sdo_o     (scfg_sdo_o),
        .busy_o    (rd_busy),
        .cnt_o     (rd_cnt)
    );
endmodule

// File: rtl/cfg_serial_target_chk.sv
// Property checker for cfg_serial_target, attached by bind below.
module cfg_serial_target_chk #(
    parameter int unsigned FCNT_W = 6,
    parameter int unsigned RCNT_W = 6,
    parameter int unsigned FRAME_W = 44,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_rise,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic              sdo,
    input logic [FCNT_W-1:0] bit_cnt,
    input logic [RCNT_W-1:0] rd_cnt
);
    // R4: output moves only after a serial clock rise or a fetch.
    assert_sdo_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !rd_stb) |=> $stable(sdo));

    // R3: a write commit follows a serial clock rise.
    assert_write_after_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(sclk_rise));

    // R4: a fetch follows a serial clock rise.
    assert_fetch_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> $past(sclk_rise));

    // R3: never a write and a fetch together.
    assert_single_command_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, rd_stb}));

    // R7: frame counter never passes the frame length.
    assert_frame_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= FCNT_W'(FRAME_W));

    // R4: read-out counter never exceeds the word width.
    assert_readout_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= RCNT_W'(DATA_W));

    // R6: no address bits are gathered while a read-out is running.
    assert_no_collect_in_readout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt != '0 && bit_cnt == '0) |=> bit_cnt == '0);
endmodule

bind cfg_serial_target cfg_serial_target_chk #(
    .FCNT_W (FCNT_W),
    .RCNT_W (RCNT_W),
    .FRAME_W(ADDR_W + DATA_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .sdo       (scfg_sdo_o),
    .bit_cnt   (bit_cnt),
    .rd_cnt    (rd_cnt)
);

// File: tb/sim_cfg_serial_target.sv
// Directed bench for cfg_serial_target: acts as the serial master.
module sim_cfg_serial_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, load = 1'b0, wsel = 1'b0, sdi = 1'b0;
    logic sdo;
    int   n_checks = 0;
    int   n_fail   = 0;
    logic [31:0] model [8];

    always #2.5 clk = ~clk;

    cfg_serial_target u0 (
        .clk(clk), .rst_n(rst_n), .scfg_clk_i(sclk), .scfg_load_i(load),
        .scfg_write_i(wsel), .scfg_sdi_i(sdi), .scfg_sdo_o(sdo)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse();
        wait_clk(3); sclk = 1'b1; wait_clk(4); sclk = 1'b0; wait_clk(3);
    endtask

    task automatic send_bits(input logic [43:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            pulse();
        end
        sdi = 1'b0;
    endtask

    task automatic load_pulse();
        load = 1'b1; wait_clk(3); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
        wait_clk(2); load = 1'b0; wait_clk(4);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        wsel = 1'b1;
        send_bits({a, d}, 44);
        load_pulse();
        wsel = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d, input string req);
        wsel = 1'b0;
        send_bits({32'h0, a}, 12);
        load_pulse();
        check({req, "/R4 idle before pulses"}, {31'h0, sdo}, 32'h0);
        for (int i = 0; i < 32; i++) begin
            pulse();
            d[i] = sdo;
        end
    endtask

    // R1: reset state of output and bank.
    task automatic t_reset();
        logic [31:0] r;
        check("R1 sdo", {31'h0, sdo}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            do_read(12'(i), r, "R1");
            check("R1 reg zero", r, 32'h0);
        end
    endtask

    // R2/R3/R4: several data patterns round-trip through the bank.
    task automatic t_patterns();
        logic [31:0] r;
        logic [31:0] pats [4] = '{32'hA5A5_0F0F, 32'h8000_0001, 32'hFFFF_FFFF, 32'h1234_5678};
        for (int i = 0; i < 8; i++) begin
            model[i] = pats[i % 4] ^ (32'h0101_0101 * i);
            do_write(12'(i), model[i]);
        end
        for (int i = 7; i >= 0; i--) begin
            do_read(12'(i), r, "R2");
            check("R3 R4 read-back", r, model[i]);
        end
    endtask

    // R5: out-of-range addresses read zero and writes change nothing.
    task automatic t_out_of_range();
        logic [31:0] r;
        do_write(12'h008, 32'hDEAD_BEEF);
        do_write(12'h800, 32'hCAFE_F00D);
        do_read(12'h008, r, "R5");
        check("R5 read 0x008", r, 32'h0);
        do_read(12'h800, r, "R5");
        check("R5 read 0x800", r, 32'h0);
        do_read(12'h000, r, "R5");
        check("R5 reg0 intact", r, model[0]);
        do_read(12'h004, r, "R5");
        check("R5 reg4 intact", r, model[4]);
    endtask

    // R7: trailing bits after the 44th are dropped; next frame starts clean.
    task automatic t_extra_bits();
        logic [31:0] r;
        wsel = 1'b1;
        send_bits({12'h003, 32'h0F1E_2D3C}, 44);
        send_bits(44'hF, 4);
        load_pulse();
        wsel = 1'b0;
        model[3] = 32'h0F1E_2D3C;
        do_read(12'h003, r, "R7");
        check("R7 extra bits ignored", r, model[3]);
        do_read(12'h002, r, "R7");
        check("R7 next frame clean", r, model[2]);
    endtask

    // R6: read immediately followed by write and read of a different register.
    task automatic t_back_to_back();
        logic [31:0] r;
        do_read(12'h005, r, "R6");
        check("R6 first read", r, model[5]);
        do_write(12'h006, 32'h7654_3210);
        model[6] = 32'h7654_3210;
        do_read(12'h006, r, "R6");
        check("R6 write after read", r, model[6]);
        do_read(12'h001, r, "R6");
        check("R6 read after read", r, model[1]);
    endtask

    initial begin
        fork
            begin
                wait_clk(150000);
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        join_none
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_patterns();
        t_out_of_range();
        t_extra_bits();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule